// File: doc/BRIEF.md
# Multi-Core Interrupt Send Dispatcher

This block is the shared front end that sits before a row of per-core interrupt register blocks. Every access carries the id of the core that issued it, and the dispatcher steers that access to the register block owned by that core, whatever the address. The per-core blocks themselves hold the status, enable and mailbox state; the dispatcher only decides where each access goes.

One address is special. A write to the send offset does not go to the requester's own block. It is an inter-processor interrupt request. The dispatcher takes a target core id and a vector number from the written word. It then issues a set-port write carrying a one-hot status word to the target core's block. The target block applies its usual set rule, so its interrupt line rises exactly as it would for a local set write. A requester or target id that names no core is answered with a one-cycle decode-error pulse, and no block sees any access. Architectural core ids map straight onto block indices.

All outputs are registered, so every result appears one clock after the access is presented.

Top module: `ipi_send_dispatch`

## Requirements
- R1: While reset is asserted, and on the first sample after reset, `blkSel`, `setHit`, `setVec`, `blkWr` and `decErr` are all zero.
- R2: An access with an in-range requester id that is not a write to the send offset produces, one cycle later, `blkSel` equal to one-hot(requester id), with `blkWr`, `blkAddr` and `blkWdata` equal to the access's write flag, address and data.
- R3: An access whose requester id is greater than or equal to `NUM_CORES` produces a one-cycle `decErr` pulse and leaves `blkSel` and `setHit` zero, including when it is a send write.
- R4: A write to the send offset (default 0x40) from an in-range requester is not forwarded: `blkSel` stays zero. Instead, one cycle later `setHit` equals one-hot(target id), where the target id is write-data bits 25:16.
- R5: For a performed send, `setVec` equals 1 shifted left by write-data bits 4:0. Data bits 31:26 and 15:5 have no effect on `setHit` or `setVec`.
- R6: A send whose target id (bits 25:16) is greater than or equal to `NUM_CORES` produces `decErr`, with `setHit` and `blkSel` zero.
- R7: A read at the send offset is an ordinary access and is forwarded to the requester's block as in R2.
- R8: A send whose target is the requesting core itself appears on `setHit` after the same one-cycle latency as a forwarded set write, and a send that directly follows a forwarded access is issued on the next cycle.
- R9: A cycle with `accVld` low yields all-zero `blkSel`, `setHit` and `decErr` on the next cycle, even if the other inputs are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accVld | input | 1 | Access present this cycle |
| accWr | input | 1 | 1 = write, 0 = read |
| accReqId | input | REQ_W (10) | Id of the requesting core |
| accAddr | input | ADDR_W (8) | Register offset |
| accWdata | input | DATA_W (32) | Write data |
| blkSel | output | NUM_CORES (4) | One-hot select of the per-core block receiving the access |
| blkWr | output | 1 | Forwarded write flag |
| blkAddr | output | ADDR_W (8) | Forwarded offset |
| blkWdata | output | DATA_W (32) | Forwarded data |
| setHit | output | NUM_CORES (4) | One-hot set-port strobe to the target block |
| setVec | output | DATA_W (32) | One-hot status bits for the set-port write |
| decErr | output | 1 | Decode-error response pulse |

## Verification
The assertions assume that the access fields are known whenever `accVld` is high. They also assume one access per cycle, with no back-pressure, since the dispatcher accepts every cycle. The stimulus changes inputs only on falling edges and samples outputs a full half-period after the capturing edge. Ids are driven both inside and outside the core count, including all-ones values, so the range checks are exercised at their edges without leaving the defined field widths.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;
  // Per-cycle decision handed from control to datapath.
  typedef struct packed {
    logic fwd;   // steer access to requester's block
    logic send;  // issue set-port write to target block
    logic err;   // answer with decode error
  } dispStrb_t;
endpackage

// File: rtl/ipi_disp_ctrl.sv
module ipi_disp_ctrl
  import ipi_disp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int REQ_W     = 10,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SEND_OFF  = 'h40,
  parameter int TGT_LSB   = 16,
  parameter int ID_W      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accVld,
  input  logic              accWr,
  input  logic [REQ_W-1:0]  accReqId,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWdata,
  output dispStrb_t         strb
);
  localparam logic [REQ_W:0] REQ_LIM = (REQ_W+1)'(NUM_CORES);
  localparam logic [ID_W:0]  TGT_LIM = (ID_W+1)'(NUM_CORES);

  logic          reqOk, tgtOk, isSend;
  logic [ID_W-1:0] tgtId;

  always_comb begin
    tgtId  = accWdata[TGT_LSB +: ID_W];
    reqOk  = {1'b0, accReqId} < REQ_LIM;
    tgtOk  = {1'b0, tgtId} < TGT_LIM;
    isSend = accWr && (accAddr == ADDR_W'(SEND_OFF));
    strb.fwd  = accVld && reqOk && !isSend;
    strb.send = accVld && reqOk && isSend && tgtOk;
    strb.err  = accVld && (!reqOk || (isSend && !tgtOk));
  end

  // R6: at most one outcome per access
  p_strb_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fwd, strb.send, strb.err}));
endmodule

// File: rtl/ipi_disp_dp.sv
module ipi_disp_dp
  import ipi_disp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int REQ_W     = 10,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int TGT_LSB   = 16,
  parameter int ID_W      = 10,
  parameter int VEC_W     = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dispStrb_t            strb,
  input  logic                 accWr,
  input  logic [REQ_W-1:0]     accReqId,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic [DATA_W-1:0]    accWdata,
  output logic [NUM_CORES-1:0] blkSel,
  output logic                 blkWr,
  output logic [ADDR_W-1:0]    blkAddr,
  output logic [DATA_W-1:0]    blkWdata,
  output logic [NUM_CORES-1:0] setHit,
  output logic [DATA_W-1:0]    setVec,
  output logic                 decErr
);
  logic [NUM_CORES-1:0] selNxt, hitNxt;
  logic [ID_W-1:0]      tgtId;
  logic [VEC_W-1:0]     vecIdx;

  assign tgtId  = accWdata[TGT_LSB +: ID_W];
  assign vecIdx = accWdata[VEC_W-1:0];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    assign selNxt[g] = strb.fwd  && (accReqId == REQ_W'(g));
    assign hitNxt[g] = strb.send && (tgtId == ID_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkSel   <= '0;
      blkWr    <= 1'b0;
      blkAddr  <= '0;
      blkWdata <= '0;
      setHit   <= '0;
      setVec   <= '0;
      decErr   <= 1'b0;
    end else begin
      blkSel <= selNxt;
      blkWr  <= strb.fwd && accWr;
      if (strb.fwd) begin
        blkAddr  <= accAddr;
        blkWdata <= accWdata;
      end
      setHit <= hitNxt;
      setVec <= strb.send ? (DATA_W'(1) << vecIdx) : '0;
      decErr <= strb.err;
    end
  end

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(blkSel));
  p_hit_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(setHit));
  p_vec_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|setHit) |-> ($countones(setVec) == 1));
  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    decErr |-> (blkSel == '0 && setHit == '0));
endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
  import ipi_disp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int REQ_W     = 10,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SEND_OFF  = 'h40,
  parameter int TGT_LSB   = 16,
  parameter int ID_W      = 10,
  parameter int VEC_W     = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accVld,
  input  logic                 accWr,
  input  logic [REQ_W-1:0]     accReqId,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic [DATA_W-1:0]    accWdata,
  output logic [NUM_CORES-1:0] blkSel,
  output logic                 blkWr,
  output logic [ADDR_W-1:0]    blkAddr,
  output logic [DATA_W-1:0]    blkWdata,
  output logic [NUM_CORES-1:0] setHit,
  output logic [DATA_W-1:0]    setVec,
  output logic                 decErr
);
  localparam logic [REQ_W:0] REQ_LIM = (REQ_W+1)'(NUM_CORES);

  initial begin
    p_core_count: assert (NUM_CORES >= 1 && NUM_CORES <= (1 << ID_W));
  end

  dispStrb_t strb;

  ipi_disp_ctrl #(
    .NUM_CORES(NUM_CORES), .REQ_W(REQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SEND_OFF(SEND_OFF), .TGT_LSB(TGT_LSB), .ID_W(ID_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .accVld(accVld), .accWr(accWr),
    .accReqId(accReqId), .accAddr(accAddr), .accWdata(accWdata), .strb(strb)
  );

  ipi_disp_dp #(
    .NUM_CORES(NUM_CORES), .REQ_W(REQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TGT_LSB(TGT_LSB), .ID_W(ID_W), .VEC_W(VEC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .accWr(accWr), .accReqId(accReqId),
    .accAddr(accAddr), .accWdata(accWdata), .blkSel(blkSel), .blkWr(blkWr),
    .blkAddr(blkAddr), .blkWdata(blkWdata), .setHit(setHit), .setVec(setVec),
    .decErr(decErr)
  );

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !accVld |=> (blkSel == '0 && setHit == '0 && !decErr));
  p_badreq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accVld && ({1'b0, accReqId} >= REQ_LIM)) |=> decErr);
  p_send_nofwd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accVld && accWr && accAddr == ADDR_W'(SEND_OFF)) |=> (blkSel == '0));
endmodule

// File: tb/sim_ipi_send_dispatch.sv
module sim_ipi_send_dispatch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accVld = 1'b0, accWr = 1'b0;
  logic [9:0]  accReqId = '0;
  logic [7:0]  accAddr = '0;
  logic [31:0] accWdata = '0;
  logic [3:0]  blkSel, setHit;
  logic        blkWr, decErr;
  logic [7:0]  blkAddr;
  logic [31:0] blkWdata, setVec;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ipi_send_dispatch u0 (
    .clk(clk), .rstN(rstN), .accVld(accVld), .accWr(accWr), .accReqId(accReqId),
    .accAddr(accAddr), .accWdata(accWdata), .blkSel(blkSel), .blkWr(blkWr),
    .blkAddr(blkAddr), .blkWdata(blkWdata), .setHit(setHit), .setVec(setVec),
    .decErr(decErr)
  );

  typedef struct packed {
    logic        vld;
    logic        wr;
    logic [9:0]  req;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [3:0]  eSel;
    logic [3:0]  eSet;
    logic [31:0] eVec;
    logic        eErr;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,10'd0,   8'h04,32'h0,         4'b0001,4'b0000,32'h0,         1'b0,8'd2}, // R2 read
    '{1'b1,1'b1,10'd2,   8'h08,32'hDEADBEEF,  4'b0100,4'b0000,32'h0,         1'b0,8'd2}, // R2 write
    '{1'b0,1'b1,10'd1,   8'h40,32'h00010003,  4'b0000,4'b0000,32'h0,         1'b0,8'd9}, // R9 idle
    '{1'b1,1'b1,10'd4,   8'h08,32'h11,        4'b0000,4'b0000,32'h0,         1'b1,8'd3}, // R3 req=4
    '{1'b1,1'b0,10'h3FF, 8'h00,32'h0,         4'b0000,4'b0000,32'h0,         1'b1,8'd3}, // R3 req all-ones
    '{1'b1,1'b1,10'd0,   8'h40,32'h00030005,  4'b0000,4'b1000,32'h00000020,  1'b0,8'd4}, // R4 0->3 vec5
    '{1'b1,1'b1,10'd3,   8'h40,32'hFC01FFFF,  4'b0000,4'b0010,32'h80000000,  1'b0,8'd5}, // R5 junk bits
    '{1'b1,1'b1,10'd1,   8'h40,32'h00020000,  4'b0000,4'b0100,32'h00000001,  1'b0,8'd5}, // R5 vec0
    '{1'b1,1'b1,10'd1,   8'h40,32'h00040003,  4'b0000,4'b0000,32'h0,         1'b1,8'd6}, // R6 tgt=4
    '{1'b1,1'b1,10'd0,   8'h40,32'h02000001,  4'b0000,4'b0000,32'h0,         1'b1,8'd6}, // R6 tgt=0x200
    '{1'b1,1'b1,10'd5,   8'h40,32'h00010001,  4'b0000,4'b0000,32'h0,         1'b1,8'd3}, // R3 send bad req
    '{1'b1,1'b0,10'd3,   8'h40,32'h0,         4'b1000,4'b0000,32'h0,         1'b0,8'd7}, // R7 read send off
    '{1'b1,1'b1,10'd2,   8'h40,32'h00020009,  4'b0000,4'b0100,32'h00000200,  1'b0,8'd8}  // R8 self send
  };

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [9:0] r,
                       input logic [7:0] a, input logic [31:0] d);
    accVld = v; accWr = w; accReqId = r; accAddr = a; accWdata = d;
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 in reset", {blkSel, setHit, setVec, blkWr, decErr, 38'h0},
                       {4'h0, 4'h0, 32'h0, 1'b0, 1'b0, 38'h0});
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {blkSel, setHit, setVec, blkWr, decErr, 38'h0}, '0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].vld, VECS[i].wr, VECS[i].req, VECS[i].addr, VECS[i].wd);
      @(negedge clk);
      chk($sformatf("R%0d row%0d", VECS[i].rq, i),
          {blkSel, setHit, setVec, decErr, 39'h0},
          {VECS[i].eSel, VECS[i].eSet, VECS[i].eVec, VECS[i].eErr, 39'h0});
      if (VECS[i].eSel != 0)
        chk($sformatf("R%0d fields row%0d", VECS[i].rq, i),
            {blkWr, blkAddr, blkWdata, 39'h0},
            {VECS[i].wr, VECS[i].addr, VECS[i].wd, 39'h0});
    end

    // R8: forwarded set write to core 1, then self send from core 1 back to back
    drive(1'b1, 1'b1, 10'd1, 8'h10, 32'h4);
    @(negedge clk);
    chk("R8 fwd set", {blkSel, setHit, 72'h0}, {4'b0010, 4'b0000, 72'h0});
    drive(1'b1, 1'b1, 10'd1, 8'h40, 32'h00010002);
    @(negedge clk);
    chk("R8 self send", {blkSel, setHit, setVec, 40'h0}, {4'b0000, 4'b0010, 32'h4, 40'h0});
    drive(1'b0, 1'b0, 10'd0, 8'h0, 32'h0);
    @(negedge clk);
    chk("R9 after burst", {blkSel, setHit, decErr, 71'h0}, '0);

    // R1: reset in the middle of a send
    drive(1'b1, 1'b1, 10'd0, 8'h40, 32'h0003001F);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 mid reset", {blkSel, setHit, setVec, blkWr, decErr, 38'h0}, '0);
    drive(1'b0, 1'b0, 10'd0, 8'h0, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule